// File: doc/BRIEF.md
# Execution Trace Event Decoder

The decoder sits beside a processor core and watches the per-cycle trace signals that the core's execute stage presents: an instruction-valid strobe, its dependent flags (branch target, indirect, condition fail, fold), the flush hint and its indirect flag, the cancel and stall indicators, a 3-bit interrupt status code, a 9-bit interrupt number and a 31-bit halfword instruction address. It turns them into qualified one-cycle event strobes. It also keeps an interrupt nesting depth and a retired-instruction count, and reports the first broken qualifier rule through a sticky flag with a reason code.

Every input passes through one register stage before anything else is done with it. Event strobes therefore follow their inputs by one clock. State that is built from those strobes (depth, retired count, latched interrupt number, violation flag) changes on the clock edge after that. A synchronous clear input, which is registered along with the other inputs, rearms the violation flag so that it can capture the next protocol error.

Top module: `trace_event_decoder`

## Requirements
- R1: Each event strobe is asserted in the cycle after its inputs were sampled, and only when its qualifier was present. Branch needs valid. Indirect needs branch and valid. Condition-fail and fold need valid. Flush-indirect needs flush. Flush and the cancel-with-stall strobe need no qualifier.
- R2: A dependent flag without its qualifier sets the violation flag. The reason codes are: 1 for branch without valid, 2 for indirect without branch, 3 for condition-fail without valid, 4 for fold without valid, and 5 for flush-indirect without flush.
- R3: Interrupt status 1 gives the entry strobe, 2 exit, 3 return and 4 vector fetch. Values 5 to 7 give no interrupt strobe and raise reason 6.
- R4: Exit status together with valid gives no exit strobe and raises reason 7.
- R5: The interrupt number output latches the sampled number whenever the status is in the range 1 to 4. It holds its value for any other status.
- R6: The nesting depth rises by one on entry and saturates at 15. It falls by one on return.
- R7: A return at depth 0 leaves the depth at 0 and raises reason 8. The return strobe is still given.
- R8: The retired counter adds 1 for each valid cycle with condition-fail low, or 2 when fold is also set in that cycle. It wraps modulo 2^16.
- R9: Cancel together with stall subtracts 1 from the retired counter. This happens in the same update as any increment from that cycle.
- R10: While the instruction strobe is high, the next-address output equals the sampled address plus 2 halfwords on a fold cycle and plus 1 halfword otherwise, modulo 2^31.
- R11: The violation flag is sticky. The reason code keeps the lowest-numbered violation of the first violating cycle. A registered clear resets both, and a clear wins over a violation in the same cycle.
- R12: With reset low at a clock edge (synchronous, active-low), every register goes to zero, so all strobes, depth, count, number and violation outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_viol_i | input | 1 | Clear for the sticky violation flag and reason |
| iv_i | input | 1 | Instruction valid in execute |
| br_i | input | 1 | Instruction is a branch target |
| ind_i | input | 1 | Branch target is indirect |
| ccfail_i | input | 1 | Conditional check failed |
| fold_i | input | 1 | Two 16-bit opcodes consumed this cycle |
| flush_i | input | 1 | PC-changing event hint |
| findbr_i | input | 1 | Flush destination is indirect |
| cancel_i | input | 1 | Current opcode cancelled |
| stall_i | input | 1 | Last signalled instruction not yet in execute |
| intstat_i | input | 3 | Interrupt status code |
| intnum_i | input | 9 | Interrupt number |
| iaddr_i | input | 31 | Instruction address in halfwords |
| ev_instr_o | output | 1 | Instruction executed strobe |
| ev_branch_o | output | 1 | Qualified branch-target strobe |
| ev_indirect_o | output | 1 | Qualified indirect-branch strobe |
| ev_ccfail_o | output | 1 | Qualified condition-fail strobe |
| ev_fold_o | output | 1 | Qualified fold strobe |
| ev_flush_o | output | 1 | Flush strobe |
| ev_flush_ind_o | output | 1 | Qualified indirect-flush strobe |
| ev_entry_o | output | 1 | Interrupt entry strobe |
| ev_exit_o | output | 1 | Interrupt exit strobe |
| ev_return_o | output | 1 | Interrupt return strobe |
| ev_vector_o | output | 1 | Vector fetch and stack push strobe |
| ev_unexec_o | output | 1 | Stalled instruction not executed, previous one cancelled |
| next_addr_o | output | 31 | Expected next halfword address |
| int_num_o | output | 9 | Latched interrupt number |
| depth_o | output | 4 | Interrupt nesting depth |
| retired_o | output | 16 | Retired instruction count |
| viol_o | output | 1 | Sticky protocol violation flag |
| reason_o | output | 4 | Reason code of the first violation |

## Verification
The embedded properties check several rules on every cycle. They compare the one-cycle lag of the qualified strobes against the sampled inputs. They check that the interrupt strobes are mutually exclusive, that the violation flag and its reason stay frozen until a clear, that depth saturates at the top and holds at zero on a return, and that the count and the latched number hold when nothing should move them. The exact arithmetic cannot be shown by those properties. That covers the count with fold and cancel combined, the priority among several violations in one cycle, the address step, and clear winning over a new violation. The bench shows these through directed sequences and seeded random traffic compared against a reference model.

// File: rtl/trace_event_decoder.sv
module trace_event_decoder #(
  parameter int IA_W    = 31,
  parameter int NUM_W   = 9,
  parameter int CNT_W   = 16,
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_viol_i,
  input  logic               iv_i,
  input  logic               br_i,
  input  logic               ind_i,
  input  logic               ccfail_i,
  input  logic               fold_i,
  input  logic               flush_i,
  input  logic               findbr_i,
  input  logic               cancel_i,
  input  logic               stall_i,
  input  logic [2:0]         intstat_i,
  input  logic [NUM_W-1:0]   intnum_i,
  input  logic [IA_W-1:0]    iaddr_i,
  output logic               ev_instr_o,
  output logic               ev_branch_o,
  output logic               ev_indirect_o,
  output logic               ev_ccfail_o,
  output logic               ev_fold_o,
  output logic               ev_flush_o,
  output logic               ev_flush_ind_o,
  output logic               ev_entry_o,
  output logic               ev_exit_o,
  output logic               ev_return_o,
  output logic               ev_vector_o,
  output logic               ev_unexec_o,
  output logic [IA_W-1:0]    next_addr_o,
  output logic [NUM_W-1:0]   int_num_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [CNT_W-1:0]   retired_o,
  output logic               viol_o,
  output logic [3:0]         reason_o
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
  localparam logic [2:0] ST_ENTRY = 3'd1, ST_EXIT = 3'd2, ST_RET = 3'd3, ST_VEC = 3'd4;

  logic q_clr, q_iv, q_br, q_ind, q_cc, q_fold, q_flush, q_findbr, q_cancel, q_stall;
  logic [2:0]       q_stat;
  logic [NUM_W-1:0] q_num;
  logic [IA_W-1:0]  q_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {q_clr, q_iv, q_br, q_ind, q_cc, q_fold, q_flush, q_findbr, q_cancel, q_stall} <= '0;
      q_stat <= '0;
      q_num  <= '0;
      q_addr <= '0;
    end else begin
      q_clr    <= clr_viol_i;
      q_iv     <= iv_i;
      q_br     <= br_i;
      q_ind    <= ind_i;
      q_cc     <= ccfail_i;
      q_fold   <= fold_i;
      q_flush  <= flush_i;
      q_findbr <= findbr_i;
      q_cancel <= cancel_i;
      q_stall  <= stall_i;
      q_stat   <= intstat_i;
      q_num    <= intnum_i;
      q_addr   <= iaddr_i;
    end
  end

  assign ev_instr_o     = q_iv;
  assign ev_branch_o    = q_iv & q_br;
  assign ev_indirect_o  = q_iv & q_br & q_ind;
  assign ev_ccfail_o    = q_iv & q_cc;
  assign ev_fold_o      = q_iv & q_fold;
  assign ev_flush_o     = q_flush;
  assign ev_flush_ind_o = q_flush & q_findbr;
  assign ev_entry_o     = (q_stat == ST_ENTRY);
  assign ev_exit_o      = (q_stat == ST_EXIT) & ~q_iv;
  assign ev_return_o    = (q_stat == ST_RET);
  assign ev_vector_o    = (q_stat == ST_VEC);
  assign ev_unexec_o    = q_cancel & q_stall;

  assign next_addr_o = q_addr + (ev_fold_o ? IA_W'(2) : IA_W'(1));

  logic stat_known;
  assign stat_known = (q_stat != 3'd0) && (q_stat <= ST_VEC);

  logic [3:0] vcode;
  always_comb begin
    if      (q_br && !q_iv)                      vcode = 4'd1;
    else if (q_ind && !q_br)                     vcode = 4'd2;
    else if (q_cc && !q_iv)                      vcode = 4'd3;
    else if (q_fold && !q_iv)                    vcode = 4'd4;
    else if (q_findbr && !q_flush)               vcode = 4'd5;
    else if (q_stat > ST_VEC)                    vcode = 4'd6;
    else if (q_stat == ST_EXIT && q_iv)          vcode = 4'd7;
    else if (q_stat == ST_RET && depth_o == '0)  vcode = 4'd8;
    else                                         vcode = 4'd0;
  end

  logic [1:0] inc;
  assign inc = (q_iv && !q_cc) ? (q_fold ? 2'd2 : 2'd1) : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_num_o <= '0;
      depth_o   <= '0;
      retired_o <= '0;
      viol_o    <= 1'b0;
      reason_o  <= '0;
    end else begin
      if (stat_known) int_num_o <= q_num;
      if (ev_entry_o) begin
        if (depth_o != DEPTH_MAX) depth_o <= depth_o + 1'b1;
      end else if (ev_return_o && depth_o != '0) begin
        depth_o <= depth_o - 1'b1;
      end
      retired_o <= retired_o + CNT_W'(inc) - CNT_W'(ev_unexec_o);
      if (q_clr) begin
        viol_o   <= 1'b0;
        reason_o <= '0;
      end else if (!viol_o && vcode != 4'd0) begin
        viol_o   <= 1'b1;
        reason_o <= vcode;
      end
    end
  end

  p_branch_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ev_branch_o == $past(br_i && iv_i)));
  p_indirect_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ev_indirect_o == $past(ind_i && br_i && iv_i)));
  p_ind_no_br_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ind && !q_br && !viol_o && !q_clr) |=> (viol_o && reason_o == 4'd2));
  p_int_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_entry_o, ev_exit_o, ev_return_o, ev_vector_o}));
  p_exit_iv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stat == ST_EXIT && q_iv && !q_clr) |=> viol_o);
  p_num_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stat == 3'd0) |=> $stable(int_num_o));
  p_depth_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_entry_o && depth_o == DEPTH_MAX) |=> (depth_o == DEPTH_MAX));
  p_ret_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_return_o && depth_o == '0 && !q_clr) |=> (viol_o && depth_o == '0));
  p_retire_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_instr_o && !ev_unexec_o) |=> $stable(retired_o));
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && !q_clr) |=> (viol_o && $stable(reason_o)));
  p_reset_r12: assert property (@(posedge clk)
    !rst_n |=> (retired_o == '0 && depth_o == '0 && !viol_o && !ev_instr_o));
endmodule

// File: tb/trace_event_decoder_bench.sv
`timescale 1ns/1ps
module trace_event_decoder_bench;
  typedef struct packed {
    logic clr, iv, br, ind, cc, fold, flush, findbr, cancel, stall;
    logic [2:0]  stat;
    logic [8:0]  num;
    logic [30:0] addr;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_viol_i = 0, iv_i = 0, br_i = 0, ind_i = 0, ccfail_i = 0, fold_i = 0;
  logic flush_i = 0, findbr_i = 0, cancel_i = 0, stall_i = 0;
  logic [2:0]  intstat_i = '0;
  logic [8:0]  intnum_i = '0;
  logic [30:0] iaddr_i = '0;
  logic ev_instr_o, ev_branch_o, ev_indirect_o, ev_ccfail_o, ev_fold_o, ev_flush_o;
  logic ev_flush_ind_o, ev_entry_o, ev_exit_o, ev_return_o, ev_vector_o, ev_unexec_o;
  logic [30:0] next_addr_o;
  logic [8:0]  int_num_o;
  logic [3:0]  depth_o;
  logic [15:0] retired_o;
  logic        viol_o;
  logic [3:0]  reason_o;

  always #2.5 clk = ~clk;

  trace_event_decoder u_trace_event_decoder (
    .clk(clk), .rst_n(rst_n), .clr_viol_i(clr_viol_i), .iv_i(iv_i), .br_i(br_i),
    .ind_i(ind_i), .ccfail_i(ccfail_i), .fold_i(fold_i), .flush_i(flush_i),
    .findbr_i(findbr_i), .cancel_i(cancel_i), .stall_i(stall_i), .intstat_i(intstat_i),
    .intnum_i(intnum_i), .iaddr_i(iaddr_i), .ev_instr_o(ev_instr_o),
    .ev_branch_o(ev_branch_o), .ev_indirect_o(ev_indirect_o), .ev_ccfail_o(ev_ccfail_o),
    .ev_fold_o(ev_fold_o), .ev_flush_o(ev_flush_o), .ev_flush_ind_o(ev_flush_ind_o),
    .ev_entry_o(ev_entry_o), .ev_exit_o(ev_exit_o), .ev_return_o(ev_return_o),
    .ev_vector_o(ev_vector_o), .ev_unexec_o(ev_unexec_o), .next_addr_o(next_addr_o),
    .int_num_o(int_num_o), .depth_o(depth_o), .retired_o(retired_o),
    .viol_o(viol_o), .reason_o(reason_o));

  int tests = 0, fails = 0;
  bit done = 0;
  stim_t prev;
  int m_depth;
  logic [15:0] m_ret;
  logic [8:0]  m_num;
  logic        m_viol;
  logic [3:0]  m_reason;

  function automatic logic [11:0] exp_events(stim_t s);
    return {s.iv, s.iv & s.br, s.iv & s.br & s.ind, s.iv & s.cc, s.iv & s.fold,
            s.flush, s.flush & s.findbr, s.stat == 3'd1, s.stat == 3'd2 && !s.iv,
            s.stat == 3'd3, s.stat == 3'd4, s.cancel & s.stall};
  endfunction

  function automatic logic [3:0] exp_code(stim_t s, int d);
    if (s.br && !s.iv) return 4'd1;
    if (s.ind && !s.br) return 4'd2;
    if (s.cc && !s.iv) return 4'd3;
    if (s.fold && !s.iv) return 4'd4;
    if (s.findbr && !s.flush) return 4'd5;
    if (s.stat > 3'd4) return 4'd6;
    if (s.stat == 3'd2 && s.iv) return 4'd7;
    if (s.stat == 3'd3 && d == 0) return 4'd8;
    return 4'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(stim_t s);
    clr_viol_i = s.clr; iv_i = s.iv; br_i = s.br; ind_i = s.ind; ccfail_i = s.cc;
    fold_i = s.fold; flush_i = s.flush; findbr_i = s.findbr; cancel_i = s.cancel;
    stall_i = s.stall; intstat_i = s.stat; intnum_i = s.num; iaddr_i = s.addr;
  endtask

  task automatic step(stim_t s);
    logic [11:0] act, exp;
    logic [3:0]  code;
    @(negedge clk);
    act = {ev_instr_o, ev_branch_o, ev_indirect_o, ev_ccfail_o, ev_fold_o, ev_flush_o,
           ev_flush_ind_o, ev_entry_o, ev_exit_o, ev_return_o, ev_vector_o, ev_unexec_o};
    exp = exp_events(prev);
    chk(act == exp, "R1 R3 R4 event strobes", int'(act), int'(exp));
    if (prev.iv)
      chk(next_addr_o == prev.addr + (prev.fold ? 31'd2 : 31'd1), "R10 next address",
          int'(next_addr_o), int'(prev.addr + (prev.fold ? 31'd2 : 31'd1)));
    chk(int_num_o == m_num, "R5 interrupt number", int'(int_num_o), int'(m_num));
    chk(depth_o == 4'(m_depth), "R6 R7 depth", int'(depth_o), m_depth);
    chk(retired_o == m_ret, "R8 R9 retired", int'(retired_o), int'(m_ret));
    chk({viol_o, reason_o} == {m_viol, m_reason}, "R2 R11 violation",
        int'({viol_o, reason_o}), int'({m_viol, m_reason}));
    code = exp_code(prev, m_depth);
    if (prev.clr) begin m_viol = 0; m_reason = 0; end
    else if (!m_viol && code != 0) begin m_viol = 1; m_reason = code; end
    if (prev.stat == 3'd1) begin if (m_depth < 15) m_depth++; end
    else if (prev.stat == 3'd3 && m_depth > 0) m_depth--;
    if (prev.stat != 0 && prev.stat <= 3'd4) m_num = prev.num;
    if (prev.iv && !prev.cc) m_ret = m_ret + (prev.fold ? 16'd2 : 16'd1);
    if (prev.cancel && prev.stall) m_ret = m_ret - 16'd1;
    apply(s);
    prev = s;
  endtask

  function automatic stim_t idle();
    stim_t s = '0;
    return s;
  endfunction

  function automatic stim_t rnd();
    stim_t s = '0;
    int k;
    s.iv = ($urandom % 4) != 0;
    s.br = s.iv && ($urandom % 3 == 0);
    s.ind = s.br && ($urandom % 2 == 0);
    s.cc = s.iv && ($urandom % 4 == 0);
    s.fold = s.iv && ($urandom % 5 == 0);
    s.flush = ($urandom % 6) == 0;
    s.findbr = s.flush && ($urandom % 2 == 0);
    s.cancel = ($urandom % 6) == 0;
    s.stall = ($urandom % 4) == 0;
    k = $urandom % 16;
    if (k < 3) s.stat = 3'd1;
    else if (k < 5) s.stat = 3'd3;
    else if (k == 5 && !s.iv) s.stat = 3'd2;
    else if (k == 6) s.stat = 3'd4;
    s.num = 9'($urandom);
    s.addr = 31'($urandom);
    s.clr = ($urandom % 30) == 0;
    if ($urandom % 25 == 0) begin
      k = $urandom % 7;
      case (k)
        0: s.br = 1'b1;
        1: s.ind = 1'b1;
        2: s.cc = 1'b1;
        3: s.fold = 1'b1;
        4: s.findbr = 1'b1;
        5: s.stat = 3'(5 + $urandom % 3);
        default: begin s.iv = 1'b1; s.stat = 3'd2; end
      endcase
    end
    return s;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    stim_t s;
    void'($urandom(32'd20240611));
    m_depth = 0; m_ret = '0; m_num = '0; m_viol = 0; m_reason = '0;
    prev = idle();
    repeat (3) @(negedge clk);
    // R12: outputs after synchronous reset edges
    chk({retired_o, depth_o, viol_o, reason_o, int_num_o, ev_instr_o, ev_flush_o} == '0,
        "R12 reset state", int'(retired_o), 0);
    rst_n = 1'b1;

    // R6: entry nesting beyond the top saturates at 15
    for (int i = 0; i < 17; i++) begin
      s = idle(); s.stat = 3'd1; s.iv = 1'b1; s.num = 9'(i + 100); step(s);
    end
    step(idle());
    for (int i = 0; i < 15; i++) begin
      s = idle(); s.stat = 3'd3; s.iv = 1'b1; step(s);
    end
    // R7: return at depth 0 gives reason 8
    s = idle(); s.stat = 3'd3; step(s);
    step(idle()); step(idle());
    s = idle(); s.clr = 1'b1; step(s);
    // R8 fold counts 2, condition fail counts 0; R10 address step
    s = idle(); s.iv = 1; s.fold = 1; s.addr = 31'h7FFF_FFFF; step(s);
    s = idle(); s.iv = 1; s.cc = 1; s.addr = 31'h100; step(s);
    // R9: cancel with stall alongside a retiring instruction
    s = idle(); s.iv = 1; s.cancel = 1; s.stall = 1; step(s);
    s = idle(); s.cancel = 1; s.stall = 1; step(s);
    s = idle(); s.cancel = 1; step(s);
    // R2: several violations in one cycle, lowest code kept; later ones ignored
    s = idle(); s.br = 1; s.findbr = 1; s.stat = 3'd6; step(s);
    s = idle(); s.fold = 1; step(s);
    step(idle());
    // R11: clear wins over a new violation in the same cycle
    s = idle(); s.clr = 1; s.cc = 1; step(s);
    step(idle());
    // R4: exit with valid; R3 illegal status after clear
    s = idle(); s.iv = 1; s.stat = 3'd2; step(s);
    s = idle(); s.clr = 1; step(s);
    s = idle(); s.stat = 3'd7; s.num = 9'h1AB; step(s);
    s = idle(); s.clr = 1; s.stat = 3'd2; s.num = 9'h055; step(s);
    s = idle(); s.stat = 3'd4; s.num = 9'h1FF; step(s);

    for (int i = 0; i < 4000; i++) step(rnd());
    repeat (3) step(idle());
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule